// File: doc/BRIEF.md
# ADC Scan Sequencer with Single-Channel Preemption

This block sequences a multi-channel analog-to-digital converter. It accepts start and stop strobes, a choice between a software strobe and an external trigger edge, a scan channel window and a single-mode channel number. It drives a converter through a request, done and abort handshake and files each result into a per-channel scan result register or a separate single-channel result register. The analog converter is outside the block; only its handshake is seen here.

A scan walks the channels from the first to the last channel in ascending order. It either stops after one pass or wraps and repeats. A second start while a scan is running preempts it. The in-flight channel is cancelled and an abort pulse is sent. After one quiet cycle the block converts the single-mode channel once and then resumes the scan at the cancelled channel. Stop has priority over everything else and returns the block to idle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, status is 0 (idle), busy, convert request and abort are low, and every result register reads 0.
- R2: With trigger select 0, a start strobe starts a scan. In the next cycle the request is high on the first scan channel and status is 1 (scanning). With trigger select 1, the start strobe is ignored and a rising edge of the external trigger starts the scan instead.
- R3: Stop wins over a start in the same cycle. Stop returns the block to idle in the next cycle from any state. If a conversion was requested or pending, abort pulses high for that one cycle.
- R4: A scan requests channels from first to last in ascending order, with one single-cycle request per channel. Each done writes its data into the scan result slot of that channel. In one-shot mode (continuous bit 0) the block goes idle after the last channel's done.
- R5: With the continuous bit 1, the channel after the last one is the first one again, and scanning goes on until stop.
- R6: A start during a scan pulses abort in the next cycle, sets status to 2 (forced single) and discards the cancelled channel's result.
- R7: In forced single, the single-mode channel is converted once and its data goes into the single result register. No scan slot is written.
- R8: After the forced single conversion is done, the next request is for the cancelled scan channel, and status returns to 1.
- R9: The cycle with abort high carries no request. A done arriving in that cycle is ignored. The next request follows one cycle later.
- R10: A start during forced single is ignored: no abort, no change of status or of the channel order.
- R11: Busy is high whenever status is not 0.
- R12: After a stop, including a stop during forced single, a new start begins at the first scan channel and not at a saved channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Software start strobe |
| stop_i | input | 1 | Stop strobe, highest priority |
| trig_sel_i | input | 1 | 0: software start, 1: external trigger edge |
| ext_trig_i | input | 1 | External trigger, rising edge starts |
| cont_i | input | 1 | 1: continuous scan, 0: one pass |
| scan_first_i | input | 3 | First scan channel |
| scan_last_i | input | 3 | Last scan channel |
| single_ch_i | input | 3 | Channel for forced single conversion |
| conv_ch_o | output | 3 | Channel being converted |
| conv_req_o | output | 1 | One-cycle convert request |
| conv_abort_o | output | 1 | One-cycle cancel of in-flight conversion |
| conv_done_i | input | 1 | Conversion done pulse |
| conv_data_i | input | 10 | Conversion result |
| status_o | output | 2 | 0 idle, 1 scanning, 2 forced single |
| busy_o | output | 1 | Sequencer active |
| scan_res_o | output | 80 | Scan results, channel n at bits n*10 +: 10 |
| single_res_o | output | 10 | Forced single result |

## Verification
The properties assume that the scan window has first not above last and that the window and single channel stay constant while the block is busy. They also assume the converter pulses done only after a request and never for a conversion already cancelled, apart from the late-done case, which the bench drives on purpose. The bench changes the configuration only while the block is idle. A converter model answers each request after a fixed latency and drops its pending answer when it sees abort. For the late-done and handshake-order cases the model is switched off and done is driven by hand.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_FORCED = 2'd2
  } seq_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT,
    PH_GAP
  } seq_phase_e;
endpackage

// File: rtl/adc_trig_decode.sv
module adc_trig_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic trig_sel_i,
  input  logic ext_trig_i,
  output logic go_o,
  output logic halt_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_trig_i;
  end

  // stop masks any start source
  assign go_o   = !stop_i && (trig_sel_i ? (ext_trig_i && !ext_q) : start_i);
  assign halt_o = stop_i;

  p_stop_masks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !go_o);
  p_sw_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i && !ext_trig_i) |-> !go_o);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic            halt_i,
  input  logic            cont_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] last_i,
  input  logic [CH_W-1:0] single_ch_i,
  input  logic            conv_done_i,
  output logic            conv_req_o,
  output logic            conv_abort_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic [1:0]      status_o,
  output logic            busy_o,
  output logic            wr_en_o,
  output logic            wr_single_o,
  output logic [CH_W-1:0] wr_ch_o
);
  import adc_seq_pkg::*;

  seq_phase_e      phase_q;
  logic            fs_q;
  logic            abort_q;
  logic [CH_W-1:0] cur_q;
  logic [CH_W-1:0] resume_q;
  seq_status_e     status;
  logic            in_flight;
  logic            preempt;

  assign in_flight = (phase_q == PH_REQ) || (phase_q == PH_WAIT);
  assign preempt   = go_i && !fs_q && in_flight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      fs_q     <= 1'b0;
      abort_q  <= 1'b0;
      cur_q    <= '0;
      resume_q <= '0;
    end else begin
      abort_q <= 1'b0;
      if (halt_i) begin
        phase_q  <= PH_IDLE;
        fs_q     <= 1'b0;
        resume_q <= '0;
        abort_q  <= in_flight;
      end else if (preempt) begin
        resume_q <= cur_q;
        cur_q    <= single_ch_i;
        fs_q     <= 1'b1;
        phase_q  <= PH_GAP;
        abort_q  <= 1'b1;
      end else begin
        unique case (phase_q)
          PH_IDLE: if (go_i) begin
            cur_q   <= first_i;
            fs_q    <= 1'b0;
            phase_q <= PH_REQ;
          end
          PH_REQ:  phase_q <= PH_WAIT;
          PH_WAIT: if (conv_done_i) begin
            if (fs_q) begin
              fs_q    <= 1'b0;
              cur_q   <= resume_q;
              phase_q <= PH_REQ;
            end else if (cur_q == last_i) begin
              if (cont_i) begin
                cur_q   <= first_i;
                phase_q <= PH_REQ;
              end else begin
                phase_q <= PH_IDLE;
              end
            end else begin
              cur_q   <= cur_q + CH_W'(1);
              phase_q <= PH_REQ;
            end
          end
          PH_GAP:  phase_q <= PH_REQ;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    if (phase_q == PH_IDLE) status = ST_IDLE;
    else if (fs_q)          status = ST_FORCED;
    else                    status = ST_SCAN;
  end

  assign conv_req_o   = (phase_q == PH_REQ);
  assign conv_abort_o = abort_q;
  assign conv_ch_o    = cur_q;
  assign status_o     = status;
  assign busy_o       = (phase_q != PH_IDLE);
  assign wr_en_o      = (phase_q == PH_WAIT) && conv_done_i && !halt_i && !preempt;
  assign wr_single_o  = fs_q;
  assign wr_ch_o      = cur_q;

  p_req_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  p_abort_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_abort_o |-> !conv_req_o);
  p_gap_then_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_abort_o && status == ST_FORCED && !halt_i) |=> conv_req_o);
  p_stop_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (status_o == 2'd0 && !busy_o));
  p_no_nest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q && busy_o && !halt_i) |=> !conv_abort_o);
  p_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && fs_q && conv_done_i && !halt_i)
      |=> (conv_req_o && conv_ch_o == $past(resume_q) && status_o == 2'd1));
  p_busy_status_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (status_o != 2'd0));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_single_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [RES_W-1:0]        wr_data_i,
  output logic [NUM_CH*RES_W-1:0] scan_res_o,
  output logic [RES_W-1:0]        single_res_o
);
  logic [NUM_CH-1:0] wr_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    assign wr_vec[g] = wr_en_i && !wr_single_i && (wr_ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        slot_q <= '0;
      else if (wr_vec[g]) slot_q <= wr_data_i;
    end
    assign scan_res_o[g*RES_W +: RES_W] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     single_res_o <= '0;
    else if (wr_en_i && wr_single_i) single_res_o <= wr_data_i;
  end

  p_one_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));
  p_single_no_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_single_i |=> $stable(scan_res_o));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          stop_i,
  input  logic                          trig_sel_i,
  input  logic                          ext_trig_i,
  input  logic                          cont_i,
  input  logic [$clog2(NUM_CH)-1:0]     scan_first_i,
  input  logic [$clog2(NUM_CH)-1:0]     scan_last_i,
  input  logic [$clog2(NUM_CH)-1:0]     single_ch_i,
  output logic [$clog2(NUM_CH)-1:0]     conv_ch_o,
  output logic                          conv_req_o,
  output logic                          conv_abort_o,
  input  logic                          conv_done_i,
  input  logic [RES_W-1:0]              conv_data_i,
  output logic [1:0]                    status_o,
  output logic                          busy_o,
  output logic [NUM_CH*RES_W-1:0]       scan_res_o,
  output logic [RES_W-1:0]              single_res_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic            go, halt;
  logic            wr_en, wr_single;
  logic [CH_W-1:0] wr_ch;

  adc_trig_decode u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .trig_sel_i(trig_sel_i),
    .ext_trig_i(ext_trig_i),
    .go_o      (go),
    .halt_o    (halt)
  );

  adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .halt_i      (halt),
    .cont_i      (cont_i),
    .first_i     (scan_first_i),
    .last_i      (scan_last_i),
    .single_ch_i (single_ch_i),
    .conv_done_i (conv_done_i),
    .conv_req_o  (conv_req_o),
    .conv_abort_o(conv_abort_o),
    .conv_ch_o   (conv_ch_o),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .wr_en_o     (wr_en),
    .wr_single_o (wr_single),
    .wr_ch_o     (wr_ch)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_single_i (wr_single),
    .wr_ch_i     (wr_ch),
    .wr_data_i   (conv_data_i),
    .scan_res_o  (scan_res_o),
    .single_res_o(single_res_o)
  );
endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int NUM_CH = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 3;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, trig_sel = 1'b0, ext_trig = 1'b0, cont = 1'b0;
  logic [CH_W-1:0] first = '0, last = '0, single_ch = '0;
  logic [CH_W-1:0] conv_ch;
  logic conv_req, conv_abort;
  logic conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic [1:0] status;
  logic busy;
  logic [NUM_CH*RES_W-1:0] scan_res;
  logic [RES_W-1:0] single_res;

  int total = 0, bad = 0;
  bit auto_en = 1'b1;
  int salt = 0;
  int ch_log[64];
  int n_log = 0;
  bit pend = 1'b0;
  int cnt = 0;
  int ch_p = 0;

  always #4 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .trig_sel_i(trig_sel), .ext_trig_i(ext_trig), .cont_i(cont),
    .scan_first_i(first), .scan_last_i(last), .single_ch_i(single_ch),
    .conv_ch_o(conv_ch), .conv_req_o(conv_req), .conv_abort_o(conv_abort),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .status_o(status), .busy_o(busy), .scan_res_o(scan_res), .single_res_o(single_res)
  );

  // converter model: answers after LAT cycles, drops answer on abort
  initial begin
    forever begin
      @(negedge clk);
      if (auto_en) begin
        conv_done = 1'b0;
        if (conv_abort) pend = 1'b0;
        else if (pend) begin
          if (cnt == 0) begin
            conv_done = 1'b1;
            conv_data = RES_W'(salt + ch_p);
            pend = 1'b0;
          end else cnt--;
        end
        if (conv_req) begin
          pend = 1'b1;
          cnt = LAT;
          ch_p = int'(conv_ch);
        end
      end
      if (conv_req && n_log < 64) begin
        ch_log[n_log] = int'(conv_ch);
        n_log++;
      end
    end
  end

  function automatic int res(input int ch);
    return int'(scan_res[ch*RES_W +: RES_W]);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic wait_idle(input string r);
    bit ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status == 2'd0) begin ok = 1'b1; break; end
    end
    chk(ok, r, int'(status), 0);
  endtask

  task automatic wait_log(input int n, input string r);
    bit ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (n_log >= n) begin ok = 1'b1; break; end
    end
    chk(ok, r, n_log, n);
  endtask

  task automatic send_done(input int d);
    @(negedge clk);
    conv_done = 1'b1;
    conv_data = RES_W'(d);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 2'd0 && !busy, "R1 idle after reset", int'(status), 0);
    chk(!conv_req && !conv_abort, "R1 handshake low", int'(conv_req), 0);
    chk(scan_res == '0 && single_res == '0, "R1 results clear", int'(single_res), 0);
  endtask

  task automatic t_oneshot();
    first = 3'd2; last = 3'd5; cont = 1'b0; salt = 100; n_log = 0;
    pulse_start();
    chk(conv_req && conv_ch == 3'd2, "R2 first request", int'(conv_ch), 2);
    chk(status == 2'd1 && busy, "R11 scanning busy", int'(status), 1);
    wait_idle("R4 one-shot ends");
    chk(n_log == 4, "R4 request count", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      chk(ch_log[i] == 2 + i, "R4 ascending order", ch_log[i], 2 + i);
      chk(res(2 + i) == 102 + i, "R4 slot data", res(2 + i), 102 + i);
    end
    chk(res(0) == 0 && res(7) == 0, "R4 other slots untouched", res(0), 0);
    chk(!busy, "R11 busy low when idle", int'(busy), 0);
  endtask

  task automatic t_hw_trig();
    trig_sel = 1'b1; n_log = 0;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(status == 2'd0 && n_log == 0, "R2 start ignored under external select", int'(status), 0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk(status == 2'd1 && conv_req, "R2 external edge starts", int'(status), 1);
    pulse_stop();
    ext_trig = 1'b0;
    trig_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_stop();
    int snap;
    snap = n_log;
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    chk(status == 2'd0 && !conv_req, "R3 stop beats start", int'(status), 0);
    chk(n_log == snap, "R3 no request after tie", n_log, snap);
    first = 3'd0; last = 3'd7;
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_stop();
    chk(status == 2'd0 && !busy, "R3 stop returns idle", int'(status), 0);
    chk(conv_abort, "R3 abort on stop", int'(conv_abort), 1);
    snap = n_log;
    repeat (8) @(negedge clk);
    chk(!conv_abort && n_log == snap, "R3 stays halted", n_log, snap);
  endtask

  task automatic t_cont();
    first = 3'd6; last = 3'd7; cont = 1'b1; salt = 300; n_log = 0;
    pulse_start();
    wait_log(5, "R5 continuous keeps going");
    pulse_stop();
    for (int i = 0; i < 5; i++)
      chk(ch_log[i] == ((i % 2) ? 7 : 6), "R5 wrap order", ch_log[i], (i % 2) ? 7 : 6);
    cont = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_preempt();
    int prev7;
    int exp_log[6] = '{1, 2, 7, 2, 3, 4};
    first = 3'd1; last = 3'd4; single_ch = 3'd7; salt = 200; cont = 1'b0;
    prev7 = res(7);
    n_log = 0;
    pulse_start();
    wait_log(2, "R6 scan reaches second channel");
    pulse_start();
    chk(conv_abort && status == 2'd2, "R6 abort and forced status", int'(status), 2);
    chk(!conv_req, "R9 no request with abort", int'(conv_req), 0);
    @(negedge clk);
    chk(conv_req && conv_ch == 3'd7, "R9 request after one gap", int'(conv_ch), 7);
    pulse_start();
    chk(!conv_abort && status == 2'd2, "R10 start ignored in forced", int'(status), 2);
    wait_idle("R8 scan completes after resume");
    chk(n_log == 6, "R8 request count", n_log, 6);
    for (int i = 0; i < 6; i++)
      chk(ch_log[i] == exp_log[i], "R8 resume order", ch_log[i], exp_log[i]);
    chk(int'(single_res) == 207, "R7 single result", int'(single_res), 207);
    chk(res(7) == prev7, "R7 scan slot untouched", res(7), prev7);
    chk(res(2) == 202, "R8 resumed channel stored", res(2), 202);
  endtask

  task automatic t_late_done();
    int prev0;
    auto_en = 1'b0; pend = 1'b0; conv_done = 1'b0;
    first = 3'd0; last = 3'd1; single_ch = 3'd5; cont = 1'b0;
    prev0 = res(0);
    pulse_start();
    chk(conv_req && conv_ch == 3'd0, "R2 manual scan start", int'(conv_ch), 0);
    @(negedge clk);
    pulse_start();
    chk(conv_abort, "R6 abort pulse", int'(conv_abort), 1);
    conv_done = 1'b1; conv_data = 10'h3FF;
    @(negedge clk);
    conv_done = 1'b0;
    chk(conv_req && conv_ch == 3'd5 && status == 2'd2, "R9 late done ignored", int'(conv_ch), 5);
    chk(res(0) == prev0, "R6 cancelled result discarded", res(0), prev0);
    chk(int'(single_res) == 207, "R9 late done not filed as single", int'(single_res), 207);
    send_done(10'h155);
    chk(int'(single_res) == 'h155, "R7 forced result stored", int'(single_res), 'h155);
    chk(conv_req && conv_ch == 3'd0 && status == 2'd1, "R8 resume at cancelled", int'(conv_ch), 0);
    send_done(10'h011);
    chk(conv_req && conv_ch == 3'd1, "R4 next channel", int'(conv_ch), 1);
    send_done(10'h022);
    chk(status == 2'd0, "R4 one-shot idle", int'(status), 0);
    chk(res(0) == 'h011 && res(1) == 'h022, "R4 manual slots", res(0), 'h011);
    auto_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_restart();
    first = 3'd3; last = 3'd5; cont = 1'b1; single_ch = 3'd0; salt = 400;
    n_log = 0;
    pulse_start();
    wait_log(2, "R12 scan reaches channel 4");
    pulse_start();
    chk(status == 2'd2, "R12 forced entered", int'(status), 2);
    @(negedge clk);
    pulse_stop();
    chk(status == 2'd0, "R12 stop from forced", int'(status), 0);
    repeat (4) @(negedge clk);
    pulse_start();
    chk(conv_req && conv_ch == 3'd3, "R12 restart at first", int'(conv_ch), 3);
    pulse_stop();
    cont = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_oneshot();
    t_hw_trig();
    t_stop();
    t_cont();
    t_preempt();
    t_late_done();
    t_restart();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule